// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Unit

This block forms the second operand of an ALU together with the shifter carry-out. It has three sources. The first is a register value shifted by a 5-bit immediate amount. The second is a register value shifted by an amount taken from the low byte of a second register. The third is an 8-bit immediate constant rotated right by an even number of positions. The first ALU operand does not pass through this block, so the unit only shapes the second input. A left shift by a constant turns a multiply by a power of two into a single operation. The rotated 8-bit form widens the range of 32-bit constants an instruction can carry.

The shift logic is combinational. An optional output register, selected by a parameter and enabled by default, adds one cycle of latency. A control module decodes the source, the shift type and the amount into a small set of strobes. The strobes cover the saturated cases (zero fill, sign fill, full-turn rotate, pass-through) and the carry source. The datapath applies those strobes to the barrel shift results.

Top module: `opnd_shifter`

## Requirements
- R1: `srcSel` picks the source. 00 shifts `opndVal` by `immShamt`. 01 shifts `opndVal` by `amtRegByte`. 10 and 11 rotate the zero-extended `immByte`. Only the amount field of the selected source has any effect.
- R2: `shiftType` codes are 00 LSL, 01 LSR, 10 ASR and 11 ROR. For LSL by n in 1..31, the result is the value shifted left by n, and the carry is bit 32-n of the input.
- R3: For LSR and ASR by n in 1..31, the vacated bits take zero (LSR) or the sign bit (ASR), and the carry is input bit n-1.
- R4: For ROR by n in 1..31, the value is rotated right by n, and the carry is bit 31 of the result. A register amount is taken modulo 32.
- R5: An amount of zero, from either the immediate field or the register byte, passes the value through unchanged, and the carry equals `carryIn`.
- R6: A register-specified LSL by exactly 32 gives zero with carry equal to input bit 0. LSR by exactly 32 gives zero with carry equal to input bit 31.
- R7: A register-specified LSL or LSR by more than 32 gives zero with a carry of zero.
- R8: A register-specified ASR by 32 or more fills every result bit with the input sign bit, and the carry equals that sign bit.
- R9: A register-specified ROR by a nonzero multiple of 32 leaves the value unchanged, and the carry equals input bit 31.
- R10: The rotated immediate is `immByte` rotated right by twice `immRot`. With `immRot` zero, the carry equals `carryIn`. Otherwise the carry equals bit 31 of the result.
- R11: With the output register enabled, results appear one clock after the inputs. While `rstN` is low, `opOut` and `carryOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| srcSel | input | 2 | Operand source select |
| shiftType | input | 2 | Shift kind for the register sources |
| opndVal | input | 32 | Register value to be shifted |
| amtRegByte | input | 8 | Low byte of the shift-amount register |
| immShamt | input | 5 | Immediate shift amount |
| immByte | input | 8 | 8-bit immediate constant |
| immRot | input | 4 | Immediate rotate field, doubled |
| carryIn | input | 1 | Incoming carry flag |
| opOut | output | 32 | Second ALU operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The hardest outputs to reach are the saturated register-amount results. These are amounts of exactly 32, amounts above 32, ASR with a positive input, and ROR by a multiple of 32. Each needs an amount byte that the 5-bit immediate path can never produce, plus an input whose bit 0, bit 31 and sign differ so that a wrong carry source is visible. The vector table drives those exact byte values (0x20, 0x21, 0x40, 0x80, 0xFF) on an operand with bit 0 and bit 31 set and bit 1 and bit 3 clear. It also repeats one byte value on the immediate source to show that the unselected amount is ignored.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int DATA_W     = 32;
  localparam int SHAMT_W    = $clog2(DATA_W);
  localparam int IMM_W      = 8;
  localparam int ROT_W      = 4;
  localparam int AMT_BYTE_W = 8;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [2:0] {
    CS_SHIFT = 3'd0,
    CS_IN    = 3'd1,
    CS_LSB   = 3'd2,
    CS_MSB   = 3'd3,
    CS_ZERO  = 3'd4
  } carry_sel_e;

  typedef struct packed {
    logic               useImm;
    logic               passThru;
    logic               forceZero;
    logic               signFill;
    carry_sel_e         carrySel;
    shift_kind_e        kind;
    logic [SHAMT_W-1:0] amt;
  } opsh_ctrl_t;
endpackage

// File: rtl/opsh_ctrl.sv
module opsh_ctrl
  import opsh_pkg::*;
(
  input  logic [1:0]            srcSel,
  input  logic [1:0]            shiftType,
  input  logic [AMT_BYTE_W-1:0] amtRegByte,
  input  logic [SHAMT_W-1:0]    immShamt,
  input  logic [ROT_W-1:0]      immRot,
  output opsh_ctrl_t            ctrl
);
  localparam logic [AMT_BYTE_W-1:0] FULL_AMT = AMT_BYTE_W'(DATA_W);

  shift_kind_e kindIn;
  assign kindIn = shift_kind_e'(shiftType);

  always_comb begin
    ctrl           = '0;
    ctrl.carrySel  = CS_SHIFT;
    ctrl.kind      = kindIn;
    ctrl.amt       = immShamt;
    if (srcSel[1]) begin
      ctrl.useImm   = 1'b1;
      ctrl.kind     = SK_ROR;
      ctrl.amt      = SHAMT_W'({immRot, 1'b0});
      if (immRot == '0) begin
        ctrl.passThru = 1'b1;
        ctrl.carrySel = CS_IN;
      end
    end else if (!srcSel[0]) begin
      if (immShamt == '0) begin
        ctrl.passThru = 1'b1;
        ctrl.carrySel = CS_IN;
      end
    end else begin
      ctrl.amt = amtRegByte[SHAMT_W-1:0];
      if (amtRegByte == '0) begin
        ctrl.passThru = 1'b1;
        ctrl.carrySel = CS_IN;
      end else begin
        unique case (kindIn)
          SK_LSL, SK_LSR: begin
            if (amtRegByte == FULL_AMT) begin
              ctrl.forceZero = 1'b1;
              ctrl.carrySel  = (kindIn == SK_LSL) ? CS_LSB : CS_MSB;
            end else if (amtRegByte > FULL_AMT) begin
              ctrl.forceZero = 1'b1;
              ctrl.carrySel  = CS_ZERO;
            end
          end
          SK_ASR: begin
            if (amtRegByte >= FULL_AMT) begin
              ctrl.signFill = 1'b1;
              ctrl.carrySel = CS_MSB;
            end
          end
          SK_ROR: begin
            if (amtRegByte[SHAMT_W-1:0] == '0) begin
              ctrl.passThru = 1'b1;
              ctrl.carrySel = CS_MSB;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8 and R7: at most one saturation override is ever active
  always_comb begin
    assert_single_override_R8: assert ($onehot0({ctrl.passThru, ctrl.forceZero, ctrl.signFill}));
  end
endmodule

// File: rtl/opsh_dp.sv
module opsh_dp
  import opsh_pkg::*;
(
  input  opsh_ctrl_t         ctrl,
  input  logic [DATA_W-1:0]  opndVal,
  input  logic [IMM_W-1:0]   immByte,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  shOut,
  output logic               shCarry
);
  logic [DATA_W-1:0]        src;
  logic [DATA_W:0]          lslT;
  logic [DATA_W:0]          lsrT;
  logic signed [DATA_W:0]   asrSrc;
  logic signed [DATA_W:0]   asrT;
  logic [DATA_W-1:0]        rorRes;
  logic [SHAMT_W-1:0]       negAmt;
  logic [DATA_W-1:0]        barrel;
  logic                     barrelC;

  assign src    = ctrl.useImm ? {{(DATA_W-IMM_W){1'b0}}, immByte} : opndVal;
  assign negAmt = SHAMT_W'(0) - ctrl.amt;
  assign lslT   = {1'b0, src} << ctrl.amt;
  assign lsrT   = {src, 1'b0} >> ctrl.amt;
  assign asrSrc = {src, 1'b0};
  assign asrT   = asrSrc >>> ctrl.amt;
  assign rorRes = (src >> ctrl.amt) | (src << negAmt);

  always_comb begin
    unique case (ctrl.kind)
      SK_LSL:  begin barrel = lslT[DATA_W-1:0]; barrelC = lslT[DATA_W];  end
      SK_LSR:  begin barrel = lsrT[DATA_W:1];   barrelC = lsrT[0];       end
      SK_ASR:  begin barrel = asrT[DATA_W:1];   barrelC = asrT[0];       end
      default: begin barrel = rorRes;           barrelC = rorRes[DATA_W-1]; end
    endcase
  end

  always_comb begin
    if (ctrl.passThru)       shOut = src;
    else if (ctrl.forceZero) shOut = '0;
    else if (ctrl.signFill)  shOut = {DATA_W{src[DATA_W-1]}};
    else                     shOut = barrel;

    unique case (ctrl.carrySel)
      CS_IN:   shCarry = carryIn;
      CS_LSB:  shCarry = src[0];
      CS_MSB:  shCarry = src[DATA_W-1];
      CS_ZERO: shCarry = 1'b0;
      default: shCarry = barrelC;
    endcase
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opsh_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            srcSel,
  input  logic [1:0]            shiftType,
  input  logic [DATA_W-1:0]     opndVal,
  input  logic [AMT_BYTE_W-1:0] amtRegByte,
  input  logic [SHAMT_W-1:0]    immShamt,
  input  logic [IMM_W-1:0]      immByte,
  input  logic [ROT_W-1:0]      immRot,
  input  logic                  carryIn,
  output logic [DATA_W-1:0]     opOut,
  output logic                  carryOut
);
  opsh_ctrl_t        ctrl;
  logic [DATA_W-1:0] shOut;
  logic              shCarry;

  opsh_ctrl u_ctrl (
    .srcSel     (srcSel),
    .shiftType  (shiftType),
    .amtRegByte (amtRegByte),
    .immShamt   (immShamt),
    .immRot     (immRot),
    .ctrl       (ctrl)
  );

  opsh_dp u_dp (
    .ctrl    (ctrl),
    .opndVal (opndVal),
    .immByte (immByte),
    .carryIn (carryIn),
    .shOut   (shOut),
    .shCarry (shCarry)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          opOut    <= '0;
          carryOut <= 1'b0;
        end else begin
          opOut    <= shOut;
          carryOut <= shCarry;
        end
      end

      assert_zero_amt_R5: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel == 2'b01 && amtRegByte == '0)
        |=> (opOut == $past(opndVal) && carryOut == $past(carryIn)));

      assert_lsl32_R6: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel == 2'b01 && shiftType == 2'b00 && amtRegByte == AMT_BYTE_W'(DATA_W))
        |=> (opOut == '0 && carryOut == $past(opndVal[0])));

      assert_big_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel == 2'b01 && !shiftType[1] && amtRegByte > AMT_BYTE_W'(DATA_W))
        |=> (opOut == '0 && !carryOut));

      assert_sign_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel == 2'b01 && shiftType == 2'b10 && amtRegByte >= AMT_BYTE_W'(DATA_W))
        |=> ((opOut == '0 || opOut == '1) && carryOut == opOut[DATA_W-1]));

      assert_rot_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel[1] && immRot == '0)
        |=> (opOut == {{(DATA_W-IMM_W){1'b0}}, $past(immByte)} && carryOut == $past(carryIn)));
    end else begin : g_comb
      assign opOut    = shOut;
      assign carryOut = shCarry;
    end
  endgenerate
endmodule

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  srcSel;
  logic [1:0]  shiftType;
  logic [31:0] opndVal;
  logic [7:0]  amtRegByte;
  logic [4:0]  immShamt;
  logic [7:0]  immByte;
  logic [3:0]  immRot;
  logic        carryIn;
  logic [31:0] opOut;
  logic        carryOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  opnd_shifter u_opnd_shifter (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .shiftType(shiftType),
    .opndVal(opndVal), .amtRegByte(amtRegByte), .immShamt(immShamt),
    .immByte(immByte), .immRot(immRot), .carryIn(carryIn),
    .opOut(opOut), .carryOut(carryOut)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [1:0]  typ;
    logic [31:0] opnd;
    logic [7:0]  amtB;
    logic [4:0]  sh;
    logic [7:0]  immB;
    logic [3:0]  rot;
    logic        cin;
    logic [31:0] expOut;
    logic        expC;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] A = 32'h800000F1;
  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, A, 8'h00, 5'd1,  8'h00, 4'd0, 1'b0, 32'h000001E2, 1'b1, 4'd2},  // R2
    '{2'd0, 2'd0, A, 8'h00, 5'd4,  8'h00, 4'd0, 1'b1, 32'h00000F10, 1'b0, 4'd2},  // R2
    '{2'd0, 2'd0, A, 8'h00, 5'd31, 8'h00, 4'd0, 1'b0, 32'h80000000, 1'b0, 4'd2},  // R2
    '{2'd0, 2'd1, A, 8'h00, 5'd1,  8'h00, 4'd0, 1'b0, 32'h40000078, 1'b1, 4'd3},  // R3
    '{2'd0, 2'd2, A, 8'h00, 5'd4,  8'h00, 4'd0, 1'b1, 32'hF800000F, 1'b0, 4'd3},  // R3
    '{2'd1, 2'd2, A, 8'd31, 5'd0,  8'h00, 4'd0, 1'b0, 32'hFFFFFFFF, 1'b0, 4'd3},  // R3
    '{2'd0, 2'd3, A, 8'h00, 5'd1,  8'h00, 4'd0, 1'b0, 32'hC0000078, 1'b1, 4'd4},  // R4
    '{2'd1, 2'd3, A, 8'h24, 5'd0,  8'h00, 4'd0, 1'b1, 32'h1800000F, 1'b0, 4'd4},  // R4
    '{2'd0, 2'd1, A, 8'h00, 5'd0,  8'h00, 4'd0, 1'b1, A,            1'b1, 4'd5},  // R5
    '{2'd1, 2'd0, A, 8'h00, 5'd5,  8'h00, 4'd0, 1'b0, A,            1'b0, 4'd5},  // R5
    '{2'd1, 2'd0, A, 8'h20, 5'd0,  8'h00, 4'd0, 1'b0, 32'h00000000, 1'b1, 4'd6},  // R6
    '{2'd1, 2'd1, A, 8'h20, 5'd0,  8'h00, 4'd0, 1'b0, 32'h00000000, 1'b1, 4'd6},  // R6
    '{2'd1, 2'd0, A, 8'h21, 5'd0,  8'h00, 4'd0, 1'b1, 32'h00000000, 1'b0, 4'd7},  // R7
    '{2'd1, 2'd1, A, 8'hFF, 5'd0,  8'h00, 4'd0, 1'b1, 32'h00000000, 1'b0, 4'd7},  // R7
    '{2'd1, 2'd2, A, 8'h40, 5'd0,  8'h00, 4'd0, 1'b0, 32'hFFFFFFFF, 1'b1, 4'd8},  // R8
    '{2'd1, 2'd2, 32'h70000001, 8'h80, 5'd0, 8'h00, 4'd0, 1'b1, 32'h00000000, 1'b0, 4'd8},  // R8
    '{2'd1, 2'd3, A, 8'h40, 5'd0,  8'h00, 4'd0, 1'b0, A,            1'b1, 4'd9},  // R9
    '{2'd2, 2'd0, A, 8'h00, 5'd0,  8'hFF, 4'd0, 1'b1, 32'h000000FF, 1'b1, 4'd10}, // R10
    '{2'd2, 2'd1, A, 8'h00, 5'd0,  8'hFF, 4'd4, 1'b0, 32'hFF000000, 1'b1, 4'd10}, // R10
    '{2'd3, 2'd0, A, 8'h00, 5'd0,  8'h3F, 4'd1, 1'b0, 32'hC000000F, 1'b1, 4'd10}, // R10
    '{2'd2, 2'd0, A, 8'h00, 5'd0,  8'h04, 4'd15, 1'b1, 32'h00000010, 1'b0, 4'd10},// R10
    '{2'd0, 2'd0, A, 8'h20, 5'd4,  8'h00, 4'd0, 1'b0, 32'h00000F10, 1'b0, 4'd1}   // R1
  };

  task automatic drive(input vec_t v);
    srcSel = v.sel; shiftType = v.typ; opndVal = v.opnd; amtRegByte = v.amtB;
    immShamt = v.sh; immByte = v.immB; immRot = v.rot; carryIn = v.cin;
  endtask

  task automatic check(input string tag, input logic [31:0] expOut, input logic expC);
    checks++;
    if (opOut !== expOut || carryOut !== expC) begin
      failures++;
      $display("FAIL %s: got out=%h carry=%b, expected out=%h carry=%b",
               tag, opOut, carryOut, expOut, expC);
    end
  endtask

  initial begin
    rstN = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    check("R11 reset state", 32'h0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].expOut, VECS[i].expC);
    end

    // R11: one-cycle latency, old value held until the next edge
    drive(VECS[6]);
    #2;
    check("R11 latency hold", VECS[NV-1].expOut, VECS[NV-1].expC);
    @(negedge clk);
    check("R11 latency update", VECS[6].expOut, VECS[6].expC);

    // R11: reset in mid-run clears the outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R11 mid-run reset", 32'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after reset release", VECS[6].expOut, VECS[6].expC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule